// File: doc/BRIEF.md
# Digital PLL lock detector

This block decides whether a phase-locked loop is in lock by watching the up and down pulses of its phase-frequency detector. A fast sampling clock measures the width of each error pulse. The measurement runs over a window that ends at a one-cycle compare strobe, which marks the end of each comparison cycle. At every strobe the measured error is sorted into one of three bands: good (small), middle, or bad (large).

The block raises an active-high lock flag after a run of consecutive good comparison cycles. A mode input selects a run of three or five. Once the flag is set, it stays set until a bad comparison cycle appears. Because the set and clear thresholds differ, lock has hysteresis. Both thresholds are parameters counted in sampling-clock periods. With the default settings and a fast sampling clock, they correspond to limits of about fifteen and twenty-five nanoseconds.

Top module: `pll_lock_monitor`

## Requirements
- R1: `lock_o` is active high and reads 0 after reset.
- R2: The phase error of a comparison cycle is the number of sampling-clock edges since the previous strobe at which exactly one of `up_i` and `dn_i` was high. Edges where both are high, and the strobe edge itself, add nothing. The count restarts at every strobe.
- R3: The error measurement saturates at 2^ERR_W-1 and does not wrap. A very long pulse is therefore still classed as bad.
- R4: A comparison cycle is good when its error is below GOOD_MAX. With `long_run_i` = 0, `lock_o` rises at the strobe edge that completes the third consecutive good cycle.
- R5: With `long_run_i` = 1, `lock_o` rises at the strobe edge that completes the fifth consecutive good cycle.
- R6: A comparison cycle with error greater than BAD_MIN clears `lock_o` at its strobe edge. An error equal to BAD_MIN does not clear it.
- R7: A cycle whose error is at least GOOD_MAX and at most BAD_MIN leaves `lock_o` unchanged and restarts the consecutive-good count.
- R8: A change of `long_run_i` restarts the consecutive-good count and leaves `lock_o` unchanged.
- R9: Reset (`rst_n` low) clears both `lock_o` and the consecutive-good count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| up_i | input | 1 | Up pulse from the phase detector |
| dn_i | input | 1 | Down pulse from the phase detector |
| strobe_i | input | 1 | One-cycle marker at the end of each comparison cycle |
| long_run_i | input | 1 | 0: three good cycles needed, 1: five |
| lock_o | output | 1 | Lock flag, active high |

## Verification
The hardest situation to reach is a run count that is silently stale. The count can be left partly built by a middle-band cycle, a mode toggle or a reset, and the flag then rises one or two strobes too early. The stimulus builds a partial run, inserts the disturbing event, and then counts the strobes again from one, so that an early rise shows up at the port. Saturation is reached with a pulse longer than the counter range, which a wrapping counter would misread as good.

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor #(
  parameter int ERR_W     = 6,
  parameter int GOOD_MAX  = 6,
  parameter int BAD_MIN   = 10,
  parameter int RUN_SHORT = 3,
  parameter int RUN_LONG  = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic up_i,
  input  logic dn_i,
  input  logic strobe_i,
  input  logic long_run_i,
  output logic lock_o
);
  localparam int RUN_W = $clog2(RUN_LONG + 2);
  localparam logic [ERR_W-1:0] ERR_SAT  = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] GOOD_LIM = ERR_W'(GOOD_MAX);
  localparam logic [ERR_W-1:0] BAD_LIM  = ERR_W'(BAD_MIN);
  localparam logic [RUN_W-1:0] RUN_S    = RUN_W'(RUN_SHORT);
  localparam logic [RUN_W-1:0] RUN_L    = RUN_W'(RUN_LONG);

  logic [ERR_W-1:0] err_q;
  logic [RUN_W-1:0] good_q;
  logic             mode_q, lock_q;

  wire             phase_err = up_i ^ dn_i;
  wire             is_good   = err_q < GOOD_LIM;
  wire             is_bad    = err_q > BAD_LIM;
  wire             mode_chg  = long_run_i != mode_q;
  wire [RUN_W-1:0] run_len   = mode_q ? RUN_L : RUN_S;
  wire [RUN_W-1:0] good_inc  = good_q + 1'b1;

  assign lock_o = lock_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_q  <= '0;
      good_q <= '0;
      mode_q <= 1'b0;
      lock_q <= 1'b0;
    end else begin
      mode_q <= long_run_i;
      if (strobe_i)
        err_q <= '0;
      else if (phase_err && err_q != ERR_SAT)
        err_q <= err_q + 1'b1;

      if (mode_chg)
        good_q <= '0;
      else if (strobe_i)
        good_q <= !is_good ? '0 : (good_q >= run_len ? good_q : good_inc);

      if (strobe_i) begin
        if (is_bad)
          lock_q <= 1'b0;
        else if (is_good && !mode_chg && good_inc >= run_len)
          lock_q <= 1'b1;
      end
    end
  end

  a_r4_rise_on_good: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> ($past(strobe_i) && $past(err_q) < GOOD_LIM));

  a_r6_fall_on_bad: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> ($past(strobe_i) && $past(err_q) > BAD_LIM));

  a_r3_err_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q == ERR_SAT && !strobe_i) |=> err_q == ERR_SAT);

  a_r8_mode_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (long_run_i != mode_q) |=> (good_q == '0 && $stable(lock_q)));

  a_r7_middle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && err_q >= GOOD_LIM && err_q <= BAD_LIM) |=> ($stable(lock_q) && good_q == '0));
endmodule

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;
  logic clk = 1'b0, rst_n = 1'b0;
  logic up_i = 1'b0, dn_i = 1'b0, strobe_i = 1'b0, long_run_i = 1'b0;
  logic lock_o;
  int   n_run = 0, n_fail = 0, cyc = 0;

  pll_lock_monitor i_pll_lock_monitor (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
    .strobe_i(strobe_i), .long_run_i(long_run_i), .lock_o(lock_o));

  always #4 clk = ~clk;

  // vector: {mode, use_dn, expected lock, requirement tag[4:0], pulse length[7:0]}
  localparam int NV = 21;
  localparam logic [15:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,5'd4,8'd2},   // R4 first good
    {1'b0,1'b1,1'b0,5'd4,8'd3},   // R4 second good
    {1'b0,1'b0,1'b1,5'd4,8'd1},   // R4 third good sets lock
    {1'b0,1'b1,1'b1,5'd7,8'd8},   // R7 middle keeps lock
    {1'b0,1'b0,1'b0,5'd6,8'd11},  // R6 bad clears lock
    {1'b0,1'b0,1'b0,5'd4,8'd5},   // R4 good 1 (5 < 6)
    {1'b0,1'b1,1'b0,5'd4,8'd5},   // R4 good 2
    {1'b0,1'b0,1'b0,5'd7,8'd8},   // R7 middle restarts the run
    {1'b0,1'b0,1'b0,5'd7,8'd0},   // R7 good 1 after restart
    {1'b0,1'b0,1'b0,5'd7,8'd0},   // R7 good 2
    {1'b0,1'b1,1'b1,5'd7,8'd0},   // R7 good 3 sets lock
    {1'b1,1'b0,1'b1,5'd8,8'd3},   // R8 mode change keeps lock
    {1'b1,1'b0,1'b0,5'd6,8'd12},  // R6 bad clears lock
    {1'b1,1'b0,1'b0,5'd5,8'd2},   // R5 good 1
    {1'b1,1'b1,1'b0,5'd5,8'd2},   // R5 good 2
    {1'b1,1'b0,1'b0,5'd5,8'd2},   // R5 good 3
    {1'b1,1'b0,1'b0,5'd5,8'd2},   // R5 good 4
    {1'b1,1'b0,1'b1,5'd5,8'd2},   // R5 good 5 sets lock
    {1'b1,1'b0,1'b1,5'd6,8'd10},  // R6 error equal to BAD_MIN keeps lock
    {1'b1,1'b1,1'b1,5'd7,8'd6},   // R7 error equal to GOOD_MAX is middle
    {1'b1,1'b0,1'b0,5'd6,8'd11}   // R6 just above BAD_MIN clears lock
  };

  task automatic check(input int tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: lock_o=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic comp_cycle(input logic mode, input logic dn, input logic both, input int len);
    @(negedge clk) long_run_i = mode;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      up_i = !dn || both;
      dn_i = dn || both;
    end
    @(negedge clk) begin up_i = 1'b0; dn_i = 1'b0; end
    @(negedge clk);
    @(negedge clk) strobe_i = 1'b1;
    @(negedge clk) strobe_i = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1, lock_o, 1'b0);                    // R1 reset state
    rst_n = 1'b1;
    @(negedge clk) check(1, lock_o, 1'b0);     // R1 still low after release

    for (int v = 0; v < NV; v++) begin
      comp_cycle(VEC[v][15], VEC[v][14], 1'b0, int'(VEC[v][7:0]));
      check(int'(VEC[v][12:8]), lock_o, VEC[v][13]);
    end

    // R3: lock, then a pulse longer than the counter range
    for (int k = 0; k < 3; k++) comp_cycle(1'b0, 1'b0, 1'b0, 1);
    check(4, lock_o, 1'b1);
    comp_cycle(1'b0, 1'b0, 1'b0, 70);
    check(3, lock_o, 1'b0);                    // R3 saturated error stays bad

    // R2: overlapping up and down counts nothing
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    comp_cycle(1'b0, 1'b1, 1'b0, 1);
    comp_cycle(1'b0, 1'b0, 1'b1, 20);
    check(2, lock_o, 1'b1);                    // R2 both-high cycle is good

    // R9: reset in lock clears the flag and the run count
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk) check(9, lock_o, 1'b0);
    rst_n = 1'b1;
    comp_cycle(1'b0, 1'b0, 1'b0, 0);
    comp_cycle(1'b0, 1'b0, 1'b0, 0);
    check(9, lock_o, 1'b0);                    // R9 count restarted at reset
    comp_cycle(1'b0, 1'b0, 1'b0, 0);
    check(9, lock_o, 1'b1);

    // R8: a mode toggle inside a partial run restarts it
    comp_cycle(1'b0, 1'b0, 1'b0, 12);
    check(6, lock_o, 1'b0);
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    @(negedge clk) long_run_i = 1'b1;
    @(negedge clk) long_run_i = 1'b0;
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    check(8, lock_o, 1'b0);                    // R8 old partial run discarded
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    comp_cycle(1'b0, 1'b0, 1'b0, 1);
    check(8, lock_o, 1'b1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule